// File: doc/BRIEF.md
# TDM Serial Link Timeslot Multiplexer

This block sits between a frame-synchronous time-division serial link and the parallel byte interfaces of a voice terminal. The link clock runs at 4.096 MHz. Each bit lasts two clocks, and a frame is 32 eight-bit channels long, giving a 2.048 Mb/s line rate and 8 kHz frames. A one-clock frame pulse marks where each frame begins.

On the transmit side, signalling bits go into channel 0, a control byte goes into channel 1, and the voice byte goes into one of two selectable bearer slots. An output-enable marks which slots are driven. Every other slot stays undriven. On the receive side, channels 0 and 1 are captured in every frame, and the voice byte is taken from the selected bearer slot. Per-slot enables, a slower signalling rate option, muting to the quiet code of either companding law, and a power-down of the voice output adjust both paths.

Top module: `tdm_slot_mux`

## Requirements
- R1: With `c_en` high, channel 1 is driven with `c_tx`, MSB first. With it low, `ser_oe` stays low for the whole of channel 1.
- R2: With `d_en` high, channel 0 is driven. Its first bit carries `d_tx[1]`, its second bit carries `d_tx[0]`, and its remaining six bits drive 1. With `d_en` low, channel 0 is not driven.
- R3: With `d_rate8` high, only the first signalling bit carries data. The second transmitted position drives 1, and `d_rx[0]` reads 1.
- R4: Channel 0 and channel 1 are captured in every frame whatever `c_en` and `d_en` are. `d_rx` is set to {first bit, second bit} of channel 0, and `c_rx` to the channel 1 byte.
- R5: `tx_b2` high puts transmit voice in channel 3, low puts it in channel 2. `rx_b2` picks channel 3 or channel 2 for `pcm_rx` in the same way.
- R6: Mute replaces the voice byte with the quiet code: 0xFF when `alaw` is 0 and 0xD5 when `alaw` is 1. `tx_mute` acts on the transmitted byte and `rx_mute` on `pcm_rx`.
- R7: With `pwr_dn` high, the selected transmit voice slot is not driven.
- R8: All other slots are never driven, and no slot is driven before the first frame pulse. After reset, `c_rx` = 0xFF, `d_rx` = 2'b11 and `pcm_rx` = 0xFF.
- R9: A frame pulse sampled high at a rising edge makes the next clock the first clock of channel 0, bit 7. Each bit spans two clocks and is sent MSB first. `ser_in` is sampled at the rising edge that ends the first clock of each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_pulse | input | 1 | One-clock frame start pulse |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | High while `ser_out` is driven |
| c_en | input | 1 | Control channel transmit enable |
| d_en | input | 1 | Signalling channel transmit enable |
| d_rate8 | input | 1 | 1: one signalling bit per frame, 0: two |
| tx_b2 | input | 1 | Transmit voice slot select (1: channel 3) |
| rx_b2 | input | 1 | Receive voice slot select (1: channel 3) |
| tx_mute | input | 1 | Send quiet code instead of `pcm_tx` |
| rx_mute | input | 1 | Present quiet code on `pcm_rx` |
| alaw | input | 1 | Companding law for quiet code (1: A-law) |
| pwr_dn | input | 1 | Stop driving the transmit voice slot |
| c_tx | input | 8 | Control byte to send |
| d_tx | input | 2 | Signalling bits to send |
| pcm_tx | input | 8 | Voice byte to send |
| c_rx | output | 8 | Last received control byte |
| d_rx | output | 2 | Last received signalling bits |
| pcm_rx | output | 8 | Last received voice byte |

## Verification
A transmitted bit is registered at the edge before its slot position, so the bit for counter position k is present for the whole cycle in which the frame counter equals k. It is built from the control inputs held during the cycle before. A received byte appears one cycle after the sample of its last bit. The voice byte of channel 3 is therefore valid from frame cycle 63 on. The driver pushes one expected item per cycle, plus three receive items at cycle 63. The monitor compares each item a quarter period after the falling edge, well clear of the rising edge at which the values change.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;

   typedef enum logic [1:0] {
      ROLE_IDLE = 2'd0,
      ROLE_SIG  = 2'd1,
      ROLE_CTL  = 2'd2,
      ROLE_VOX  = 2'd3
   } slot_role_e;

   localparam logic [7:0] QUIET_MU = 8'hFF;
   localparam logic [7:0] QUIET_A  = 8'hD5;

   function automatic logic [7:0] quiet_code(input logic a_law);
      return a_law ? QUIET_A : QUIET_MU;
   endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
   parameter int NUM_SLOTS    = 32,
   parameter int SLOT_BITS    = 8,
   parameter int CLKS_PER_BIT = 2,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int BIT_W  = $clog2(SLOT_BITS),
   localparam int PH_W   = $clog2(CLKS_PER_BIT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_pulse,
   output logic [SLOT_W-1:0] cur_slot,
   output logic [BIT_W-1:0]  cur_bit,
   output logic [PH_W-1:0]   cur_phase,
   output logic              cur_sync,
   output logic [SLOT_W-1:0] nxt_slot,
   output logic [BIT_W-1:0]  nxt_bit,
   output logic [PH_W-1:0]   nxt_phase,
   output logic              nxt_sync
);
   localparam int CNT_W = SLOT_W + BIT_W + PH_W;

   if ((1 << SLOT_W) != NUM_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two");
   end
   if ((1 << BIT_W) != SLOT_BITS) begin : g_bad_bits
      $error("SLOT_BITS must be a power of two");
   end
   if (CLKS_PER_BIT < 2 || (1 << PH_W) != CLKS_PER_BIT) begin : g_bad_cpb
      $error("CLKS_PER_BIT must be a power of two of at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             sync_q;

   assign cnt_nxt  = frm_pulse ? '0 : cnt_q + CNT_W'(1);
   assign nxt_sync = sync_q | frm_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sync_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         sync_q <= nxt_sync;
      end
   end

   assign cur_slot  = cnt_q[CNT_W-1 -: SLOT_W];
   assign cur_bit   = cnt_q[PH_W +: BIT_W];
   assign cur_phase = cnt_q[PH_W-1:0];
   assign cur_sync  = sync_q;
   assign nxt_slot  = cnt_nxt[CNT_W-1 -: SLOT_W];
   assign nxt_bit   = cnt_nxt[PH_W +: BIT_W];
   assign nxt_phase = cnt_nxt[PH_W-1:0];

   // a frame pulse always restarts the count at channel 0, first bit
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frm_pulse |=> (cur_slot == '0 && cur_bit == '0 && cur_phase == '0 && cur_sync));

endmodule

// File: rtl/tdm_slot_role.sv
module tdm_slot_role
   import tdm_mux_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int SIG_SLOT  = 0,
   parameter int CTL_SLOT  = 1,
   parameter int VOX1_SLOT = 2,
   parameter int VOX2_SLOT = 3,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic              use_second,
   output slot_role_e        role
);
   localparam int NUM_ROLES = 4;
   localparam int ROLE_SLOT [NUM_ROLES] = '{SIG_SLOT, CTL_SLOT, VOX1_SLOT, VOX2_SLOT};

   for (genvar i = 0; i < NUM_ROLES; i++) begin : g_chk_range
      if (ROLE_SLOT[i] < 0 || ROLE_SLOT[i] >= NUM_SLOTS) begin : g_bad
         $error("role slot out of frame");
      end
      for (genvar j = i + 1; j < NUM_ROLES; j++) begin : g_chk_dup
         if (ROLE_SLOT[i] == ROLE_SLOT[j]) begin : g_bad
            $error("role slots must be distinct");
         end
      end
   end

   logic [NUM_ROLES-1:0] hit;
   for (genvar i = 0; i < NUM_ROLES; i++) begin : g_hit
      assign hit[i] = (slot == SLOT_W'(ROLE_SLOT[i]));
   end

   always_comb begin
      role = ROLE_IDLE;
      if (hit[0])                    role = ROLE_SIG;
      else if (hit[1])               role = ROLE_CTL;
      else if (hit[2] && !use_second) role = ROLE_VOX;
      else if (hit[3] && use_second)  role = ROLE_VOX;
   end

endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
   import tdm_mux_pkg::*;
#(
   parameter int NUM_SLOTS    = 32,
   parameter int SLOT_BITS    = 8,
   parameter int CLKS_PER_BIT = 2,
   parameter int SIG_SLOT     = 0,
   parameter int CTL_SLOT     = 1,
   parameter int VOX1_SLOT    = 2,
   parameter int VOX2_SLOT    = 3,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int BIT_W  = $clog2(SLOT_BITS),
   localparam int PH_W   = $clog2(CLKS_PER_BIT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SLOT_W-1:0]    nxt_slot,
   input  logic [BIT_W-1:0]     nxt_bit,
   input  logic [PH_W-1:0]      nxt_phase,
   input  logic                 nxt_sync,
   input  logic                 c_en,
   input  logic                 d_en,
   input  logic                 d_rate8,
   input  logic                 tx_b2,
   input  logic                 tx_mute,
   input  logic                 alaw,
   input  logic                 pwr_dn,
   input  logic [SLOT_BITS-1:0] c_tx,
   input  logic [1:0]           d_tx,
   input  logic [SLOT_BITS-1:0] pcm_tx,
   output logic                 ser_out,
   output logic                 ser_oe
);
   if (SLOT_BITS != 8) begin : g_bad_width
      $error("quiet codes are defined for 8-bit slots only");
   end

   slot_role_e           role;
   logic [SLOT_BITS-1:0] slot_byte;
   logic                 slot_drive;
   logic                 bit_val;

   tdm_slot_role #(
      .NUM_SLOTS(NUM_SLOTS), .SIG_SLOT(SIG_SLOT), .CTL_SLOT(CTL_SLOT),
      .VOX1_SLOT(VOX1_SLOT), .VOX2_SLOT(VOX2_SLOT)
   ) u_role (
      .slot(nxt_slot), .use_second(tx_b2), .role(role)
   );

   always_comb begin
      slot_byte  = '1;
      slot_drive = 1'b0;
      unique case (role)
         ROLE_SIG: begin
            slot_drive = d_en;
            slot_byte  = {d_tx[1], (d_rate8 ? 1'b1 : d_tx[0]), {(SLOT_BITS-2){1'b1}}};
         end
         ROLE_CTL: begin
            slot_drive = c_en;
            slot_byte  = c_tx;
         end
         ROLE_VOX: begin
            slot_drive = !pwr_dn;
            slot_byte  = tx_mute ? quiet_code(alaw) : pcm_tx;
         end
         default: begin
            slot_drive = 1'b0;
            slot_byte  = '1;
         end
      endcase
   end

   assign bit_val = slot_byte[BIT_W'(SLOT_BITS-1) - nxt_bit];

   // output changes only where a new bit begins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_out <= 1'b1;
         ser_oe  <= 1'b0;
      end else if (nxt_phase == '0) begin
         ser_out <= bit_val;
         ser_oe  <= nxt_sync && slot_drive;
      end
   end

   // within a bit the line holds its level
   p_bit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_phase != '0) |=> ($stable(ser_out) && $stable(ser_oe)));

endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture
   import tdm_mux_pkg::*;
#(
   parameter int NUM_SLOTS    = 32,
   parameter int SLOT_BITS    = 8,
   parameter int CLKS_PER_BIT = 2,
   parameter int SIG_SLOT     = 0,
   parameter int CTL_SLOT     = 1,
   parameter int VOX1_SLOT    = 2,
   parameter int VOX2_SLOT    = 3,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int BIT_W  = $clog2(SLOT_BITS),
   localparam int PH_W   = $clog2(CLKS_PER_BIT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SLOT_W-1:0]    cur_slot,
   input  logic [BIT_W-1:0]     cur_bit,
   input  logic [PH_W-1:0]      cur_phase,
   input  logic                 cur_sync,
   input  logic                 ser_in,
   input  logic                 rx_b2,
   input  logic                 rx_mute,
   input  logic                 alaw,
   input  logic                 d_rate8,
   output logic [SLOT_BITS-1:0] c_rx,
   output logic [1:0]           d_rx,
   output logic [SLOT_BITS-1:0] pcm_rx
);
   localparam logic [PH_W-1:0] SAMPLE_PH = PH_W'(CLKS_PER_BIT/2 - 1);

   if (SLOT_BITS != 8) begin : g_bad_width
      $error("quiet codes are defined for 8-bit slots only");
   end

   slot_role_e           role;
   logic [SLOT_BITS-2:0] shift_q;
   logic [SLOT_BITS-1:0] full_byte;
   logic                 take;
   logic                 last;

   tdm_slot_role #(
      .NUM_SLOTS(NUM_SLOTS), .SIG_SLOT(SIG_SLOT), .CTL_SLOT(CTL_SLOT),
      .VOX1_SLOT(VOX1_SLOT), .VOX2_SLOT(VOX2_SLOT)
   ) u_role (
      .slot(cur_slot), .use_second(rx_b2), .role(role)
   );

   assign take      = cur_sync && (cur_phase == SAMPLE_PH);
   assign last      = take && (cur_bit == BIT_W'(SLOT_BITS-1));
   assign full_byte = {shift_q, ser_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '1;
      end else if (take) begin
         shift_q <= full_byte[SLOT_BITS-2:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_rx   <= '1;
         d_rx   <= 2'b11;
         pcm_rx <= '1;
      end else if (last) begin
         unique case (role)
            ROLE_SIG: d_rx   <= {full_byte[SLOT_BITS-1], (d_rate8 ? 1'b1 : full_byte[SLOT_BITS-2])};
            ROLE_CTL: c_rx   <= full_byte;
            ROLE_VOX: pcm_rx <= rx_mute ? quiet_code(alaw) : full_byte;
            default:  ;
         endcase
      end
   end

   p_sig8_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (last && role == ROLE_SIG && d_rate8) |=> d_rx[0]);

   p_rx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (last && role == ROLE_VOX && rx_mute) |=> (pcm_rx == quiet_code($past(alaw))));

   p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> ($stable(c_rx) && $stable(d_rx) && $stable(pcm_rx)));

endmodule

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux #(
   parameter int NUM_SLOTS    = 32,
   parameter int SLOT_BITS    = 8,
   parameter int CLKS_PER_BIT = 2,
   parameter int SIG_SLOT     = 0,
   parameter int CTL_SLOT     = 1,
   parameter int VOX1_SLOT    = 2,
   parameter int VOX2_SLOT    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frm_pulse,
   input  logic                 ser_in,
   output logic                 ser_out,
   output logic                 ser_oe,
   input  logic                 c_en,
   input  logic                 d_en,
   input  logic                 d_rate8,
   input  logic                 tx_b2,
   input  logic                 rx_b2,
   input  logic                 tx_mute,
   input  logic                 rx_mute,
   input  logic                 alaw,
   input  logic                 pwr_dn,
   input  logic [SLOT_BITS-1:0] c_tx,
   input  logic [1:0]           d_tx,
   input  logic [SLOT_BITS-1:0] pcm_tx,
   output logic [SLOT_BITS-1:0] c_rx,
   output logic [1:0]           d_rx,
   output logic [SLOT_BITS-1:0] pcm_rx
);
   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam int BIT_W  = $clog2(SLOT_BITS);
   localparam int PH_W   = $clog2(CLKS_PER_BIT);

   logic [SLOT_W-1:0] cur_slot, nxt_slot;
   logic [BIT_W-1:0]  cur_bit, nxt_bit;
   logic [PH_W-1:0]   cur_phase, nxt_phase;
   logic              cur_sync, nxt_sync;

   tdm_frame_timer #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .CLKS_PER_BIT(CLKS_PER_BIT)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .frm_pulse(frm_pulse),
      .cur_slot(cur_slot), .cur_bit(cur_bit), .cur_phase(cur_phase), .cur_sync(cur_sync),
      .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_phase(nxt_phase), .nxt_sync(nxt_sync)
   );

   tdm_tx_mux #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .CLKS_PER_BIT(CLKS_PER_BIT),
      .SIG_SLOT(SIG_SLOT), .CTL_SLOT(CTL_SLOT), .VOX1_SLOT(VOX1_SLOT), .VOX2_SLOT(VOX2_SLOT)
   ) u_tx (
      .clk(clk), .rst_n(rst_n),
      .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_phase(nxt_phase), .nxt_sync(nxt_sync),
      .c_en(c_en), .d_en(d_en), .d_rate8(d_rate8), .tx_b2(tx_b2), .tx_mute(tx_mute),
      .alaw(alaw), .pwr_dn(pwr_dn), .c_tx(c_tx), .d_tx(d_tx), .pcm_tx(pcm_tx),
      .ser_out(ser_out), .ser_oe(ser_oe)
   );

   tdm_rx_capture #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .CLKS_PER_BIT(CLKS_PER_BIT),
      .SIG_SLOT(SIG_SLOT), .CTL_SLOT(CTL_SLOT), .VOX1_SLOT(VOX1_SLOT), .VOX2_SLOT(VOX2_SLOT)
   ) u_rx (
      .clk(clk), .rst_n(rst_n),
      .cur_slot(cur_slot), .cur_bit(cur_bit), .cur_phase(cur_phase), .cur_sync(cur_sync),
      .ser_in(ser_in), .rx_b2(rx_b2), .rx_mute(rx_mute), .alaw(alaw), .d_rate8(d_rate8),
      .c_rx(c_rx), .d_rx(d_rx), .pcm_rx(pcm_rx)
   );

   // slot-level output rules, checked against the running frame position
   p_unsynced_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_sync |-> !ser_oe);

   p_idle_slots_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_slot != SLOT_W'(SIG_SLOT) && cur_slot != SLOT_W'(CTL_SLOT) &&
       cur_slot != SLOT_W'(VOX1_SLOT) && cur_slot != SLOT_W'(VOX2_SLOT)) |-> !ser_oe);

   p_ctl_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_slot == SLOT_W'(CTL_SLOT) && cur_phase == '0 && !$past(c_en)) |-> !ser_oe);

   p_vox_pwrdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_slot == ($past(tx_b2) ? SLOT_W'(VOX2_SLOT) : SLOT_W'(VOX1_SLOT)) &&
       cur_phase == '0 && $past(pwr_dn)) |-> !ser_oe);

endmodule

// File: tb/test_tdm_slot_mux.sv
`timescale 1ns/1ps
module test_tdm_slot_mux;
   localparam int CLK_PER = 244;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_pulse = 1'b0;
   logic       ser_in = 1'b1;
   logic       ser_out, ser_oe;
   logic       c_en = 0, d_en = 0, d_rate8 = 0, tx_b2 = 0, rx_b2 = 0;
   logic       tx_mute = 0, rx_mute = 0, alaw = 0, pwr_dn = 0;
   logic [7:0] c_tx = 0, pcm_tx = 0;
   logic [1:0] d_tx = 0;
   logic [7:0] c_rx, pcm_rx;
   logic [1:0] d_rx;

   always #(CLK_PER/2) clk = ~clk;

   tdm_slot_mux i_tdm_slot_mux (
      .clk(clk), .rst_n(rst_n), .frm_pulse(frm_pulse), .ser_in(ser_in),
      .ser_out(ser_out), .ser_oe(ser_oe), .c_en(c_en), .d_en(d_en), .d_rate8(d_rate8),
      .tx_b2(tx_b2), .rx_b2(rx_b2), .tx_mute(tx_mute), .rx_mute(rx_mute), .alaw(alaw),
      .pwr_dn(pwr_dn), .c_tx(c_tx), .d_tx(d_tx), .pcm_tx(pcm_tx),
      .c_rx(c_rx), .d_rx(d_rx), .pcm_rx(pcm_rx)
   );

   typedef struct {
      logic c_en, d_en, rate8, tx_b2, rx_b2, tx_mute, rx_mute, alaw, pwr_dn;
      logic [7:0] c_tx; logic [1:0] d_tx; logic [7:0] pcm_tx;
      logic [7:0] rx0, rx1, rx2, rx3;
   } cfg_t;

   // kind 0: line (exp[1] = oe, exp[0] = bit); 1: c_rx; 2: d_rx; 3: pcm_rx
   typedef struct { int kind; string req; logic [7:0] exp; } item_t;

   item_t q[$];
   int    n_run = 0;
   int    n_fail = 0;

   function automatic logic [7:0] quiet(input logic a);
      return a ? 8'hD5 : 8'hFF;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: compares queued expectations a quarter period after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PER/4);
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            case (it.kind)
               0: if (it.exp[1]) check(it.req, {6'b0, ser_oe, ser_out}, it.exp);
                  else           check(it.req, {7'b0, ser_oe}, 8'h00);
               1: check(it.req, c_rx, it.exp);
               2: check(it.req, {6'b0, d_rx}, it.exp);
               default: check(it.req, pcm_rx, it.exp);
            endcase
         end
      end
   end

   function automatic item_t line_exp(input cfg_t c, input int k);
      item_t it;
      int ch = k / 16;
      int bi = (k / 2) % 8;
      logic [7:0] b = 8'hFF;
      logic oe = 1'b0;
      it.kind = 0;
      it.req  = "R8";
      if (ch == 0) begin
         oe = c.d_en; b = {c.d_tx[1], (c.rate8 ? 1'b1 : c.d_tx[0]), 6'h3F};
         it.req = c.rate8 ? "R3" : "R2";
      end else if (ch == 1) begin
         oe = c.c_en; b = c.c_tx; it.req = "R1";
      end else if (ch == (c.tx_b2 ? 3 : 2)) begin
         oe = !c.pwr_dn; b = c.tx_mute ? quiet(c.alaw) : c.pcm_tx;
         it.req = c.pwr_dn ? "R7" : (c.tx_mute ? "R6" : "R5");
      end
      if (ch < 2 && bi == 0) it.req = {it.req, "/R9"};
      it.exp = {6'b0, oe, b[7-bi]};
      return it;
   endfunction

   function automatic logic rx_line(input cfg_t c, input int k);
      int ch = k / 16;
      int bi = (k / 2) % 8;
      case (ch)
         0: return c.rx0[7-bi];
         1: return c.rx1[7-bi];
         2: return c.rx2[7-bi];
         3: return c.rx3[7-bi];
         default: return logic'(k[5] ^ k[1]);
      endcase
   endfunction

   // driver: entered at the falling edge of the frame pulse cycle
   task automatic run_frame(input cfg_t c);
      item_t it;
      c_en = c.c_en; d_en = c.d_en; d_rate8 = c.rate8; tx_b2 = c.tx_b2; rx_b2 = c.rx_b2;
      tx_mute = c.tx_mute; rx_mute = c.rx_mute; alaw = c.alaw; pwr_dn = c.pwr_dn;
      c_tx = c.c_tx; d_tx = c.d_tx; pcm_tx = c.pcm_tx;
      frm_pulse = 1'b1; ser_in = 1'b1;
      it.kind = 0; it.req = "R8"; it.exp = 8'h00; q.push_back(it);
      @(negedge clk);
      frm_pulse = 1'b0;
      for (int k = 0; k < 511; k++) begin
         ser_in = rx_line(c, k);
         q.push_back(line_exp(c, k));
         if (k == 63) begin
            it.kind = 1; it.req = "R4"; it.exp = c.rx1; q.push_back(it);
            it.kind = 2; it.req = c.rate8 ? "R3" : "R4";
            it.exp = {6'b0, c.rx0[7], (c.rate8 ? 1'b1 : c.rx0[6])}; q.push_back(it);
            it.kind = 3; it.req = c.rx_mute ? "R6" : "R5";
            it.exp = c.rx_mute ? quiet(c.alaw) : (c.rx_b2 ? c.rx3 : c.rx2); q.push_back(it);
         end
         @(negedge clk);
      end
   endtask

   function automatic cfg_t base_cfg(input logic [7:0] seed);
      cfg_t c;
      c.c_en = 1; c.d_en = 1; c.rate8 = 0; c.tx_b2 = 0; c.rx_b2 = 0;
      c.tx_mute = 0; c.rx_mute = 0; c.alaw = 0; c.pwr_dn = 0;
      c.c_tx = 8'hA5 ^ seed; c.d_tx = seed[1:0] ^ 2'b10; c.pcm_tx = 8'h3C + seed;
      c.rx0 = 8'h9C ^ seed; c.rx1 = 8'h5A + seed; c.rx2 = 8'h71 ^ seed; c.rx3 = 8'hE2 - seed;
      return c;
   endfunction

   initial begin
      #(CLK_PER * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      cfg_t c;
      item_t it;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset values and no drive before any frame pulse
      check("R8", c_rx, 8'hFF);
      check("R8", {6'b0, d_rx}, 8'h03);
      check("R8", pcm_rx, 8'hFF);
      for (int i = 0; i < 6; i++) begin
         it.kind = 0; it.req = "R8"; it.exp = 8'h00; q.push_back(it);
         @(negedge clk);
      end
      // R1 R2 R5 R9: everything on, first bearer slot
      c = base_cfg(8'h00); run_frame(c);
      // R5: second bearer slot both ways
      c = base_cfg(8'h13); c.tx_b2 = 1; c.rx_b2 = 1; run_frame(c);
      // R4: enables off, receive still captured
      c = base_cfg(8'h2E); c.c_en = 0; c.d_en = 0; run_frame(c);
      // R3: one signalling bit per frame
      c = base_cfg(8'h41); c.rate8 = 1; c.d_tx = 2'b10; c.rx0 = 8'h80; run_frame(c);
      // R6: mute, mu-law quiet code
      c = base_cfg(8'h57); c.tx_mute = 1; c.rx_mute = 1; run_frame(c);
      // R6: mute, A-law quiet code, second slot
      c = base_cfg(8'h68); c.tx_mute = 1; c.rx_mute = 1; c.alaw = 1; c.tx_b2 = 1; run_frame(c);
      // R7: voice output powered down
      c = base_cfg(8'h7B); c.pwr_dn = 1; run_frame(c);
      // R5: mixed selects, R2 with d_tx = 01
      c = base_cfg(8'h8C); c.rx_b2 = 1; c.d_tx = 2'b01; run_frame(c);
      // final frame pulse cycle (slot 31) is idle
      it.kind = 0; it.req = "R8"; it.exp = 8'h00; q.push_back(it);
      frm_pulse = 1'b0;
      @(negedge clk);
      #(CLK_PER/2);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule